// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Logic

This block is the issue-stage control of a two-wide in-order pipeline. Each cycle, fetch presents a 64-bit packet that holds two 32-bit instructions. The lower half is the left slot, meant for integer and memory work. The upper half is the right slot, meant for floating-point operations. The block decides whether neither, one or both of the two instructions leave issue in the current cycle. It keeps issue strictly in program order, and the right instruction never leaves ahead of its left partner.

A load's result arrives one cycle late. Three instructions therefore cannot use the loaded register: the load's partner in the same packet, and both instructions of the packet issued in the following cycle. The block records the destination of the last load that issued. For exactly one cycle it stalls any instruction that reads that register. When only the left instruction can go, the block asks fetch to present the same packet again. It also remembers internally that the left half has already issued. The right half then goes alone in a later cycle. A redirect input discards the packet in flight in the same cycle.

Top module: `pair_issue_unit`

## Requirements
- R1: After reset, with no packet offered, all four outputs are low. The first packet offered after reset issues its left instruction if that instruction has no hazard.
- R2: The left instruction is pktData[31:0] and the right instruction is pktData[63:32]. In each instruction, opcode = [31:26], src1 = [25:21], src2 = [20:16] and dst = [15:11].
  - An opcode whose top two bits are 11 is an FP operation. It reads FP registers src1 and src2 and writes FP register dst.
  - Opcode 100000 is an integer load. It reads integer register src1 and writes integer register dst.
  - Opcode 100001 is an FP load. It reads integer register src1 and writes FP register dst.
  - Every other opcode is an integer ALU operation. It reads integer registers src1 and src2 and writes integer register dst.
- R3: When the left instruction is not an FP operation, the right instruction is an FP operation, and neither has a hazard, both issue in the same cycle. In that cycle pairAdvance is high and fetchHold is low. This includes an FP load on the left paired with an FP operation on the right.
- R4: issueRight is high only in a cycle where issueLeft is also high, or after the left instruction of the same packet has already issued.
- R5: If the left instruction is an FP operation, or the right instruction is not an FP operation, only the left instruction issues and fetchHold is high. On a later cycle the right instruction issues alone and the left one is not issued again. pairAdvance is high exactly in the cycle the right instruction issues, and fetchHold is high in every earlier cycle of that packet.
- R6: If a left-slot load writes a register that the right instruction reads (same register file), the right instruction is not issued with the load. It is not issued in the next cycle either, and issues in the cycle after that.
- R7: In the cycle after a load issues, an instruction that reads the loaded register in the same register file does not issue. If that instruction is in the left slot, nothing issues that cycle. From the second cycle after the load, the stall is gone.
- R8: A load whose destination is register 0 never causes a stall. A load never stalls an instruction that reads the same register number in the other register file.
- R9: In a cycle with redirect high, no instruction issues, and fetchHold and pairAdvance are low. The next packet starts with its left instruction, even if the previous packet's left half had already issued.
- R10: In a cycle with pktValid low, no instruction issues, and fetchHold and pairAdvance are low. A pending load stall lasts exactly one cycle, whether or not a packet is offered in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pktValid | input | 1 | Fetch packet present this cycle |
| pktData | input | 64 | Two instructions: left slot in bits 31:0, right slot in bits 63:32 |
| redirect | input | 1 | Flush: discard the packet in flight and any load tracking |
| issueLeft | output | 1 | Left-slot instruction issues this cycle |
| issueRight | output | 1 | Right-slot instruction issues this cycle |
| fetchHold | output | 1 | Fetch must present the same packet next cycle |
| pairAdvance | output | 1 | Packet is finished; fetch may move to the next one |

## Verification
The hardest situation to reach from the ports is when several stall reasons land on the same right-slot instruction in different cycles. For example, a stall from the previous packet's load, a refused pairing and a partner hazard from its own left-slot load can all delay it, and each of these pushes the issue cycle further out. The bench reaches these cases by placing a load packet directly in front of each test packet. It then sweeps every combination of left class, right class and load kind, combined with every on/off choice of three register dependencies. Register 0 and cross-file register numbers are also included. For each case the bench works out the left and right issue cycles arithmetically, and checks all four outputs on every cycle until the packet finishes.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int INST_W = 32;
  localparam int OPC_W  = 6;
  localparam int REG_AW = 5;

  typedef enum logic [1:0] {
    CLS_ALU  = 2'd0,
    CLS_LDI  = 2'd1,
    CLS_LDF  = 2'd2,
    CLS_FPOP = 2'd3
  } instCls_t;

  typedef struct packed {
    instCls_t          cls;
    logic [REG_AW-1:0] src1;
    logic [REG_AW-1:0] src2;
    logic [REG_AW-1:0] dst;
  } decInst_t;

  typedef struct packed {
    logic captureLeft;
    logic captureRight;
    logic flush;
  } dpStrobe_t;
endpackage

// File: rtl/pair_decode.sv
module pair_decode
  import pair_pkg::*;
#(
  parameter int IW = INST_W
) (
  input  logic [IW-1:0] inst,
  output decInst_t      dec
);
  localparam int SRC1_HI = IW - OPC_W - 1;
  localparam int SRC2_HI = SRC1_HI - REG_AW;
  localparam int DST_HI  = SRC2_HI - REG_AW;
  localparam int LOW_W   = DST_HI - REG_AW + 1;

  logic [OPC_W-1:0] opc;
  logic             unusedLow;

  assign opc       = inst[IW-1 -: OPC_W];
  assign unusedLow = ^inst[LOW_W-1:0];

  always_comb begin
    dec.src1 = inst[SRC1_HI -: REG_AW];
    dec.src2 = inst[SRC2_HI -: REG_AW];
    dec.dst  = inst[DST_HI -: REG_AW];
    if (opc[OPC_W-1 -: 2] == 2'b11)
      dec.cls = CLS_FPOP;
    else if (opc == OPC_W'(6'b100000))
      dec.cls = CLS_LDI;
    else if (opc == OPC_W'(6'b100001))
      dec.cls = CLS_LDF;
    else
      dec.cls = CLS_ALU;
  end
endmodule

// File: rtl/pair_datapath.sv
module pair_datapath
  import pair_pkg::*;
#(
  parameter int IW    = INST_W,
  parameter int SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOTS*IW-1:0] pktData,
  input  dpStrobe_t         strobe,
  output logic              leftHazPrev,
  output logic              rightHazPrev,
  output logic              rightHazPartner,
  output logic              leftIsFpOp,
  output logic              rightIsFpOp
);
  decInst_t slotDec [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_dec
    pair_decode #(.IW(IW)) u_dec (
      .inst (pktData[s*IW +: IW]),
      .dec  (slotDec[s])
    );
  end

  logic              pendValid;
  logic              pendFp;
  logic [REG_AW-1:0] pendReg;

  function automatic logic readsReg(decInst_t d, logic inFp, logic [REG_AW-1:0] r);
    logic hit;
    hit = 1'b0;
    if (r != '0) begin
      unique case (d.cls)
        CLS_FPOP: hit = inFp && (d.src1 == r || d.src2 == r);
        CLS_ALU:  hit = !inFp && (d.src1 == r || d.src2 == r);
        default:  hit = !inFp && (d.src1 == r);
      endcase
    end
    return hit;
  endfunction

  function automatic logic isLoad(decInst_t d);
    return (d.cls == CLS_LDI) || (d.cls == CLS_LDF);
  endfunction

  decInst_t leftDec;
  decInst_t rightDec;
  decInst_t srcDec;
  logic     srcValid;

  assign leftDec  = slotDec[0];
  assign rightDec = slotDec[SLOTS-1];

  assign leftIsFpOp      = (leftDec.cls == CLS_FPOP);
  assign rightIsFpOp     = (rightDec.cls == CLS_FPOP);
  assign leftHazPrev     = pendValid && readsReg(leftDec, pendFp, pendReg);
  assign rightHazPrev    = pendValid && readsReg(rightDec, pendFp, pendReg);
  assign rightHazPartner = isLoad(leftDec) &&
                           readsReg(rightDec, leftDec.cls == CLS_LDF, leftDec.dst);

  always_comb begin
    srcDec   = strobe.captureLeft ? leftDec : rightDec;
    srcValid = (strobe.captureLeft || strobe.captureRight) &&
               isLoad(srcDec) && (srcDec.dst != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendValid <= 1'b0;
      pendFp    <= 1'b0;
      pendReg   <= '0;
    end else if (strobe.flush) begin
      pendValid <= 1'b0;
      pendFp    <= 1'b0;
      pendReg   <= '0;
    end else begin
      pendValid <= srcValid;
      pendFp    <= (srcDec.cls == CLS_LDF);
      pendReg   <= srcDec.dst;
    end
  end
endmodule

// File: rtl/pair_ctrl.sv
module pair_ctrl
  import pair_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pktValid,
  input  logic      redirect,
  input  logic      leftHazPrev,
  input  logic      rightHazPrev,
  input  logic      rightHazPartner,
  input  logic      leftIsFpOp,
  input  logic      rightIsFpOp,
  output logic      issueLeft,
  output logic      issueRight,
  output logic      fetchHold,
  output logic      pairAdvance,
  output dpStrobe_t strobe
);
  logic leftTaken;
  logic live;
  logic pairOk;
  logic rightPaired;
  logic rightSolo;

  assign live        = pktValid && !redirect;
  assign pairOk      = !leftIsFpOp && rightIsFpOp;
  assign issueLeft   = live && !leftTaken && !leftHazPrev;
  assign rightPaired = issueLeft && pairOk && !rightHazPrev && !rightHazPartner;
  assign rightSolo   = live && leftTaken && !rightHazPrev;
  assign issueRight  = rightPaired || rightSolo;
  assign pairAdvance = issueRight;
  assign fetchHold   = live && !issueRight;

  assign strobe.captureLeft  = issueLeft;
  assign strobe.captureRight = issueRight && !issueLeft;
  assign strobe.flush        = redirect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       leftTaken <= 1'b0;
    else if (redirect || issueRight)  leftTaken <= 1'b0;
    else if (issueLeft)               leftTaken <= 1'b1;
  end
endmodule

// File: rtl/pair_issue_unit.sv
module pair_issue_unit
  import pair_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pktValid,
  input  logic [63:0]   pktData,
  input  logic          redirect,
  output logic          issueLeft,
  output logic          issueRight,
  output logic          fetchHold,
  output logic          pairAdvance
);
  dpStrobe_t strobe;
  logic leftHazPrev, rightHazPrev, rightHazPartner, leftIsFpOp, rightIsFpOp;

  pair_datapath #(.IW(INST_W), .SLOTS(2)) u_dp (
    .clk             (clk),
    .rst_n           (rst_n),
    .pktData         (pktData),
    .strobe          (strobe),
    .leftHazPrev     (leftHazPrev),
    .rightHazPrev    (rightHazPrev),
    .rightHazPartner (rightHazPartner),
    .leftIsFpOp      (leftIsFpOp),
    .rightIsFpOp     (rightIsFpOp)
  );

  pair_ctrl u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .pktValid        (pktValid),
    .redirect        (redirect),
    .leftHazPrev     (leftHazPrev),
    .rightHazPrev    (rightHazPrev),
    .rightHazPartner (rightHazPartner),
    .leftIsFpOp      (leftIsFpOp),
    .rightIsFpOp     (rightIsFpOp),
    .issueLeft       (issueLeft),
    .issueRight      (issueRight),
    .fetchHold       (fetchHold),
    .pairAdvance     (pairAdvance),
    .strobe          (strobe)
  );
endmodule

// File: rtl/pair_issue_checks.sv
module pair_issue_checks (
  input logic clk,
  input logic rst_n,
  input logic pktValid,
  input logic redirect,
  input logic issueLeft,
  input logic issueRight,
  input logic fetchHold,
  input logic pairAdvance
);
  logic leftSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      leftSeen <= 1'b0;
    else if (redirect || issueRight) leftSeen <= 1'b0;
    else if (issueLeft)              leftSeen <= 1'b1;
  end

  assert_right_follows_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issueRight |-> (issueLeft || leftSeen));

  assert_no_reissue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issueLeft |-> !leftSeen);

  assert_hold_excludes_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetchHold |-> (!pairAdvance && pktValid));

  assert_advance_ends_packet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pairAdvance |=> !leftSeen);

  assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!issueLeft && !issueRight && !fetchHold && !pairAdvance));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pktValid |-> (!issueLeft && !issueRight && !fetchHold && !pairAdvance));
endmodule

bind pair_issue_unit pair_issue_checks u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .pktValid    (pktValid),
  .redirect    (redirect),
  .issueLeft   (issueLeft),
  .issueRight  (issueRight),
  .fetchHold   (fetchHold),
  .pairAdvance (pairAdvance)
);

// File: tb/pair_issue_unit_bench.sv
`timescale 1ns/1ps
module pair_issue_unit_bench;
  localparam int ALU = 0, LDI = 1, LDF = 2, FPOP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pktValid = 1'b0;
  logic [63:0] pktData = '0;
  logic redirect = 1'b0;
  logic issueLeft, issueRight, fetchHold, pairAdvance;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pair_issue_unit u_pair_issue_unit (
    .clk(clk), .rst_n(rst_n), .pktValid(pktValid), .pktData(pktData),
    .redirect(redirect), .issueLeft(issueLeft), .issueRight(issueRight),
    .fetchHold(fetchHold), .pairAdvance(pairAdvance)
  );

  function automatic logic [31:0] mk(int cls, int s1, int s2, int d);
    logic [5:0] op;
    case (cls)
      LDI:     op = 6'b100000;
      LDF:     op = 6'b100001;
      FPOP:    op = 6'b110000;
      default: op = 6'b000001;
    endcase
    return {op, 5'(s1), 5'(s2), 5'(d), 11'h2a5};
  endfunction

  function automatic bit reads(int cls, bit inFp, int r, int s1, int s2);
    if (r == 0) return 1'b0;
    if (cls == FPOP) return inFp && (s1 == r || s2 == r);
    if (cls == ALU)  return !inFp && (s1 == r || s2 == r);
    return !inFp && (s1 == r);
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic chkAll(string tag, logic eL, logic eR, logic eH, logic eA);
    chk(tag, "issueLeft", issueLeft, eL);
    chk(tag, "issueRight", issueRight, eR);
    chk(tag, "fetchHold", fetchHold, eH);
    chk(tag, "pairAdvance", pairAdvance, eA);
  endtask

  task automatic idleCycle();
    @(negedge clk);
    pktValid = 1'b0; redirect = 1'b0; pktData = '1;
    #2 chkAll("R10", 0, 0, 0, 0);
  endtask

  task automatic runCase(int pk, int lc, int rc, bit depL, bit depR, bit depP);
    bit prevOn, prevFp, pend, leftLoad, leftFp, hz, seenL;
    int pd, expL, expR, ls1, rs1, rs2;
    string tag;
    logic [63:0] testPkt;
    prevOn = (pk != 0);
    prevFp = (pk == 2 || pk == 4);
    pd     = (pk >= 3) ? 0 : 5;
    ls1 = depL ? pd : 7;
    rs1 = depR ? pd : 9;
    rs2 = depP ? 12 : 10;
    testPkt = {mk(rc, rs1, rs2, 13), mk(lc, ls1, 8, 12)};
    pend     = prevOn && pd != 0;
    leftLoad = (lc == LDI || lc == LDF);
    leftFp   = (lc == LDF);
    expL = (pend && reads(lc, prevFp, pd, ls1, 8)) ? 1 : 0;
    expR = expL + 3;
    for (int c = expL; c <= expL + 3; c++) begin
      hz = 1'b0;
      if (pend && c == 0 && reads(rc, prevFp, pd, rs1, rs2)) hz = 1'b1;
      if (leftLoad && (c == expL || c == expL + 1) && reads(rc, leftFp, 12, rs1, rs2)) hz = 1'b1;
      if (c == expL && !(lc != FPOP && rc == FPOP)) hz = 1'b1;
      if (!hz) begin expR = c; break; end
    end
    tag = "R3";
    if (!(lc != FPOP && rc == FPOP)) tag = "R5";
    if (leftLoad && depP) tag = "R6";
    if (pend && (depL || depR)) tag = "R7";
    if (prevOn && pd == 0) tag = "R8";

    idleCycle();
    if (prevOn) begin
      @(negedge clk);
      pktValid = 1'b1;
      pktData = {mk(FPOP, 20, 21, 22), mk(prevFp ? LDF : LDI, 1, 2, pd)};
      #2 chkAll("R3", 1, 1, 0, 1);
    end
    seenL = 1'b0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      pktValid = 1'b1; pktData = testPkt;
      #2;
      chkAll(tag, c == expL, c == expR, c < expR, c == expR);
      chk("R4", "rightBeforeLeft", issueRight && !issueLeft && !seenL, 1'b0);
      if (issueLeft) seenL = 1'b1;
      if (c >= expR) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet after reset, then first packet issues left
    @(negedge clk);
    #2 chkAll("R1", 0, 0, 0, 0);
    @(negedge clk);
    pktValid = 1'b1; pktData = {mk(FPOP, 1, 2, 3), mk(ALU, 4, 5, 6)};
    #2 chkAll("R1", 1, 1, 0, 1);
    idleCycle();

    // R9: redirect on a half-issued packet
    @(negedge clk);
    pktValid = 1'b1; pktData = {mk(FPOP, 1, 2, 3), mk(FPOP, 4, 5, 6)};
    #2 chkAll("R9", 1, 0, 1, 0);
    @(negedge clk);
    redirect = 1'b1;
    #2 chkAll("R9", 0, 0, 0, 0);
    @(negedge clk);
    redirect = 1'b0; pktData = {mk(FPOP, 1, 2, 3), mk(ALU, 4, 5, 6)};
    #2 chkAll("R9", 1, 1, 0, 1);
    // R9: redirect right after a load, dependent packet after it
    @(negedge clk);
    pktData = {mk(FPOP, 1, 2, 3), mk(LDI, 4, 5, 9)};
    #2 chkAll("R9", 1, 1, 0, 1);
    @(negedge clk);
    redirect = 1'b1; pktData = {mk(FPOP, 1, 2, 3), mk(ALU, 9, 9, 6)};
    #2 chkAll("R9", 0, 0, 0, 0);
    @(negedge clk);
    redirect = 1'b0;
    #2 chkAll("R9", 1, 1, 0, 1);

    // R10: load stall expires across an empty cycle
    @(negedge clk);
    pktData = {mk(FPOP, 1, 2, 3), mk(LDI, 4, 5, 9)};
    #2 chkAll("R10", 1, 1, 0, 1);
    idleCycle();
    @(negedge clk);
    pktValid = 1'b1; pktData = {mk(FPOP, 1, 2, 3), mk(ALU, 9, 9, 6)};
    #2 chkAll("R10", 1, 1, 0, 1);

    // Sweep: R2 encodings across all class pairs, loads and dependencies
    for (int pk = 0; pk < 5; pk++)
      for (int lc = 0; lc < 4; lc++)
        for (int rc = 0; rc < 4; rc++)
          for (int dm = 0; dm < 8; dm++)
            runCase(pk, lc, rc, dm[0], dm[1], dm[2]);
    idleCycle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule